// File: doc/BRIEF.md
# Hex Hash Entry Controller

This block is the operator-facing state machine of a brute-force search appliance. It lets a user type in a 64-bit target hash as sixteen hexadecimal digits, launch the search engine, cancel it, and read back the recovered plaintext together with the time the search took. It takes single-cycle pulses from four debounced pushbuttons, one toggle switch, a found flag and a found-key bus from the engine. It drives the target hash, two sixteen-character text lines for a character display, the index and phase of the blinking digit, a run control that holds the engine in reset outside a run, and an elapsed-minutes count.

The block has three modes: setup, running and found. In setup the digits are edited one at a time. The selected digit blinks on line one and moves left or right under button 3. Starting a run locks the hash and clears the timer. A found report freezes the timer and puts the plaintext on line one. The switch together with button 0 always returns the block to setup.

Top module: `hash_entry_ui`

## Requirements
- R1: After reset the block is in setup with hash zero, selection 0 (leftmost digit), `engine_run` low, `minutes` zero and `blink_on` high.
- R2: In setup, `btn[2]` increments and `btn[1]` decrements the selected 4-bit digit, wrapping F to 0 and 0 to F. Digit i occupies `target_hash[4*(DIGITS-1-i) +: 4]`, and no other digit changes.
- R3: In setup, `btn[3]` moves the selection one digit right when `sw` is 1 and one digit left when `sw` is 0. The selection saturates at 0 and at DIGITS-1.
- R4: In setup, pulses that arrive together are resolved by priority: `btn[0]` first, then `btn[3]`, then `btn[2]`, then `btn[1]`. While `btn[0]` is high, no edit happens.
- R5: In setup, line one holds each digit as uppercase ASCII ('0'-'9' = 0x30-0x39, 'A'-'F' = 0x41-0x46), with character i at bits `[8*i +: 8]`. The selected character is a space (0x20) while `blink_on` is low, and `blink_on` toggles every BLINK_DIV cycles. Line two is all spaces.
- R6: In setup, `btn[0]` with `sw` at 0 enters running. This raises `engine_run`, clears `minutes` and starts the timer. `btn[0]` with `sw` at 1 has no effect in setup.
- R7: In running, buttons 1 to 3 have no effect on the hash or the selection. Line one shows every hash digit without blanking.
- R8: In running, `minutes` increments by one every CYC_PER_MIN cycles. Line two shows it as MIN_W/4 uppercase hex digits right-aligned, with spaces before them.
- R9: A `found_i` pulse in running enters found mode and drops `engine_run`. Line one then shows `found_key`, and `minutes` and line two stay frozen. `found_i` in any other mode has no effect.
- R10: `btn[0]` with `sw` at 1 returns to setup from running or found, keeping the hash and the selection. `btn[0]` with `sw` at 0 has no effect in running or found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn | input | 4 | Single-cycle button pulses: 0 go/back, 1 decrement, 2 increment, 3 move |
| sw | input | 1 | Toggle switch: move direction (1 = right) and go/back qualifier |
| found_i | input | 1 | Engine reports a match |
| found_key | input | 8*DIGITS | Recovered plaintext, character i at bits [8*i +: 8] |
| target_hash | output | 4*DIGITS | Hash under search, digit 0 in the top nibble |
| line1 | output | 8*DIGITS | First display line, character i at bits [8*i +: 8] |
| line2 | output | 8*DIGITS | Second display line |
| blink_idx | output | $clog2(DIGITS) | Index of the selected digit |
| blink_on | output | 1 | Blink phase, high = selected digit visible |
| engine_run | output | 1 | High only in running; the engine is held in reset when low |
| minutes | output | MIN_W | Elapsed minutes of the current or last run |

## Verification
The bench builds the block with BLINK_DIV = 5 and CYC_PER_MIN = 20 and keeps DIGITS = 16 and MIN_W = 16. With these values the blink period and the minute boundary can be measured cycle-exactly, and two whole minutes elapse, and then stay frozen, within a few hundred cycles. With the full sixteen digits, the selection can be walked to both ends and checked for saturation, and edits to several neighbouring digits can be checked for wrap.

// File: rtl/hue_pkg.sv
package hue_pkg;

  typedef enum logic [1:0] {
    MODE_SETUP = 2'd0,
    MODE_RUN   = 2'd1,
    MODE_FOUND = 2'd2
  } ui_mode_t;

  localparam int BTN_GO   = 0;
  localparam int BTN_DEC  = 1;
  localparam int BTN_INC  = 2;
  localparam int BTN_MOVE = 3;

  localparam logic [7:0] CH_SPACE = 8'h20;

  function automatic logic [7:0] hex_char(input logic [3:0] v);
    if (v < 4'd10) return 8'h30 + {4'h0, v};
    else           return 8'h37 + {4'h0, v};
  endfunction

endpackage

// File: rtl/hue_digit_editor.sv
module hue_digit_editor #(
  parameter int DIGITS = 16,
  localparam int SEL_W = $clog2(DIGITS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  edit_en,
  input  logic                  do_move,
  input  logic                  move_right,
  input  logic                  do_inc,
  input  logic                  do_dec,
  output logic [4*DIGITS-1:0]   hash_o,
  output logic [SEL_W-1:0]      sel_o
);

  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(DIGITS - 1);

  logic [3:0]       digit_q [DIGITS];
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (edit_en && do_move) begin
      if (move_right) begin
        if (sel_q != SEL_MAX) sel_q <= sel_q + 1'b1;
      end else begin
        if (sel_q != '0) sel_q <= sel_q - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    always_ff @(posedge clk) begin
      if (rst) begin
        digit_q[g] <= 4'h0;
      end else if (edit_en && !do_move && (sel_q == SEL_W'(g))) begin
        if (do_inc)      digit_q[g] <= digit_q[g] + 4'h1;
        else if (do_dec) digit_q[g] <= digit_q[g] - 4'h1;
      end
    end
    assign hash_o[4*(DIGITS-1-g) +: 4] = digit_q[g];
  end

  assign sel_o = sel_q;

  AST_HASH_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !edit_en |=> $stable(hash_o)); // R7

  AST_SEL_STEP: assert property (@(posedge clk) disable iff (rst)
    (sel_q != $past(sel_q)) |-> ((sel_q == $past(sel_q) + 1'b1) || ($past(sel_q) == sel_q + 1'b1))); // R3

endmodule

// File: rtl/hue_timebase.sv
module hue_timebase #(
  parameter int          BLINK_DIV   = 12_500_000,
  parameter int unsigned CYC_PER_MIN = 32'd3_000_000_000,
  parameter int          MIN_W       = 16,
  localparam int BLK_W = $clog2(BLINK_DIV),
  localparam int CYC_W = $clog2(CYC_PER_MIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             count_en,
  output logic             blink_o,
  output logic [MIN_W-1:0] minutes_o
);

  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLINK_DIV - 1);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_MIN - 1);

  logic [BLK_W-1:0] blk_cnt_q;
  logic             blink_q;
  logic [CYC_W-1:0] cyc_q;
  logic [MIN_W-1:0] min_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_cnt_q <= '0;
      blink_q   <= 1'b1;
    end else if (blk_cnt_q == BLK_LAST) begin
      blk_cnt_q <= '0;
      blink_q   <= ~blink_q;
    end else begin
      blk_cnt_q <= blk_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cyc_q <= '0;
      min_q <= '0;
    end else if (count_en) begin
      if (cyc_q == CYC_LAST) begin
        cyc_q <= '0;
        min_q <= min_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign blink_o   = blink_q;
  assign minutes_o = min_q;

  AST_MIN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!count_en && !clear) |=> $stable(minutes_o)); // R9

  AST_MIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (count_en && !clear) |=> ((minutes_o == $past(minutes_o)) || (minutes_o == $past(minutes_o) + 1'b1))); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (minutes_o == '0)); // R6

endmodule

// File: rtl/hue_display.sv
module hue_display
  import hue_pkg::*;
#(
  parameter int DIGITS = 16,
  parameter int MIN_W  = 16,
  localparam int SEL_W   = $clog2(DIGITS),
  localparam int MIN_DIG = MIN_W / 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ui_mode_t              mode,
  input  logic [4*DIGITS-1:0]   hash,
  input  logic [SEL_W-1:0]      sel,
  input  logic                  blink,
  input  logic [MIN_W-1:0]      minutes,
  input  logic [8*DIGITS-1:0]   found_key,
  output logic [8*DIGITS-1:0]   line1_o,
  output logic [8*DIGITS-1:0]   line2_o,
  output logic                  blink_on_o,
  output logic [SEL_W-1:0]      blink_idx_o
);

  logic [8*DIGITS-1:0] line1_d, line2_d;

  for (genvar g = 0; g < DIGITS; g++) begin : g_col
    logic [7:0] hex_c;
    logic       hide;
    assign hex_c = hex_char(hash[4*(DIGITS-1-g) +: 4]);
    assign hide  = (mode == MODE_SETUP) && (sel == SEL_W'(g)) && !blink;
    assign line1_d[8*g +: 8] = (mode == MODE_FOUND) ? found_key[8*g +: 8] :
                               (hide ? CH_SPACE : hex_c);

    if (g >= DIGITS - MIN_DIG) begin : g_min
      assign line2_d[8*g +: 8] = (mode == MODE_SETUP) ? CH_SPACE :
                                 hex_char(minutes[4*(DIGITS-1-g) +: 4]);
    end else begin : g_pad
      assign line2_d[8*g +: 8] = CH_SPACE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line1_o     <= {DIGITS{CH_SPACE}};
      line2_o     <= {DIGITS{CH_SPACE}};
      blink_on_o  <= 1'b1;
      blink_idx_o <= '0;
    end else begin
      line1_o     <= line1_d;
      line2_o     <= line2_d;
      blink_on_o  <= blink;
      blink_idx_o <= sel;
    end
  end

  AST_FOUND_SHOWS_KEY: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FOUND) |=> (line1_o == $past(found_key))); // R9

endmodule

// File: rtl/hash_entry_ui.sv
module hash_entry_ui
  import hue_pkg::*;
#(
  parameter int          DIGITS      = 16,
  parameter int          BLINK_DIV   = 12_500_000,
  parameter int unsigned CYC_PER_MIN = 32'd3_000_000_000,
  parameter int          MIN_W       = 16,
  localparam int SEL_W = $clog2(DIGITS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [3:0]            btn,
  input  logic                  sw,
  input  logic                  found_i,
  input  logic [8*DIGITS-1:0]   found_key,
  output logic [4*DIGITS-1:0]   target_hash,
  output logic [8*DIGITS-1:0]   line1,
  output logic [8*DIGITS-1:0]   line2,
  output logic [SEL_W-1:0]      blink_idx,
  output logic                  blink_on,
  output logic                  engine_run,
  output logic [MIN_W-1:0]      minutes
);

  ui_mode_t         mode_q, mode_d;
  logic             go_start, go_back;
  logic             edit_en, do_move, do_inc, do_dec;
  logic [SEL_W-1:0] sel;
  logic             blink;

  assign go_start = (mode_q == MODE_SETUP) && btn[BTN_GO] && !sw;
  assign go_back  = (mode_q != MODE_SETUP) && btn[BTN_GO] && sw;

  assign edit_en = (mode_q == MODE_SETUP) && !btn[BTN_GO];
  assign do_move = btn[BTN_MOVE];
  assign do_inc  = !btn[BTN_MOVE] && btn[BTN_INC];
  assign do_dec  = !btn[BTN_MOVE] && !btn[BTN_INC] && btn[BTN_DEC];

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_SETUP: if (go_start) mode_d = MODE_RUN;
      MODE_RUN: begin
        if (go_back)      mode_d = MODE_SETUP;
        else if (found_i) mode_d = MODE_FOUND;
      end
      MODE_FOUND: if (go_back) mode_d = MODE_SETUP;
      default: mode_d = MODE_SETUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_SETUP;
    else     mode_q <= mode_d;
  end

  assign engine_run = (mode_q == MODE_RUN);

  hue_digit_editor #(.DIGITS(DIGITS)) u_edit (
    .clk        (clk),
    .rst        (rst),
    .edit_en    (edit_en),
    .do_move    (do_move),
    .move_right (sw),
    .do_inc     (do_inc),
    .do_dec     (do_dec),
    .hash_o     (target_hash),
    .sel_o      (sel)
  );

  hue_timebase #(
    .BLINK_DIV   (BLINK_DIV),
    .CYC_PER_MIN (CYC_PER_MIN),
    .MIN_W       (MIN_W)
  ) u_time (
    .clk       (clk),
    .rst       (rst),
    .clear     (go_start),
    .count_en  (mode_q == MODE_RUN),
    .blink_o   (blink),
    .minutes_o (minutes)
  );

  hue_display #(.DIGITS(DIGITS), .MIN_W(MIN_W)) u_disp (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode_q),
    .hash        (target_hash),
    .sel         (sel),
    .blink       (blink),
    .minutes     (minutes),
    .found_key   (found_key),
    .line1_o     (line1),
    .line2_o     (line2),
    .blink_on_o  (blink_on),
    .blink_idx_o (blink_idx)
  );

  AST_RUN_FROM_SETUP: assert property (@(posedge clk) disable iff (rst)
    (engine_run && !$past(engine_run)) |-> ($past(mode_q) == MODE_SETUP)); // R6

  AST_FOUND_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == MODE_FOUND) && ($past(mode_q) != MODE_FOUND)) |-> ($past(mode_q) == MODE_RUN)); // R9

  AST_BACK_TO_SETUP: assert property (@(posedge clk) disable iff (rst)
    ((mode_q != MODE_SETUP) && btn[BTN_GO] && sw) |=> (mode_q == MODE_SETUP)); // R10

endmodule

// File: tb/sim_hash_entry_ui.sv
module sim_hash_entry_ui;

  localparam int DIGITS = 16;
  localparam int BLINK  = 5;
  localparam int CYC    = 20;
  localparam int MIN_W  = 16;
  localparam int NVEC   = 11;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [3:0]         btn = 4'h0;
  logic               sw  = 1'b0;
  logic               found_i = 1'b0;
  logic [127:0]       found_key = '0;
  logic [63:0]        target_hash;
  logic [127:0]       line1, line2;
  logic [3:0]         blink_idx;
  logic               blink_on, engine_run;
  logic [15:0]        minutes;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  hash_entry_ui #(
    .DIGITS(DIGITS), .BLINK_DIV(BLINK), .CYC_PER_MIN(CYC), .MIN_W(MIN_W)
  ) u0 (
    .clk(clk), .rst(rst), .btn(btn), .sw(sw), .found_i(found_i),
    .found_key(found_key), .target_hash(target_hash), .line1(line1),
    .line2(line2), .blink_idx(blink_idx), .blink_on(blink_on),
    .engine_run(engine_run), .minutes(minutes)
  );

  // {btn, sw, expected hash, expected selection}
  localparam logic [72:0] VEC [NVEC] = '{
    {4'b0010, 1'b0, 64'hF000_0000_0000_0000, 4'd0},  // R2 dec wraps 0->F
    {4'b0100, 1'b0, 64'h0000_0000_0000_0000, 4'd0},  // R2 inc wraps F->0
    {4'b0100, 1'b0, 64'h1000_0000_0000_0000, 4'd0},  // R2
    {4'b1000, 1'b0, 64'h1000_0000_0000_0000, 4'd0},  // R3 left saturates
    {4'b1000, 1'b1, 64'h1000_0000_0000_0000, 4'd1},  // R3 right
    {4'b0100, 1'b0, 64'h1100_0000_0000_0000, 4'd1},  // R2
    {4'b0010, 1'b0, 64'h1000_0000_0000_0000, 4'd1},  // R2
    {4'b0010, 1'b0, 64'h1F00_0000_0000_0000, 4'd1},  // R2
    {4'b1100, 1'b1, 64'h1F00_0000_0000_0000, 4'd2},  // R4 move beats inc
    {4'b0110, 1'b0, 64'h1F10_0000_0000_0000, 4'd2},  // R4 inc beats dec
    {4'b0011, 1'b1, 64'h1F10_0000_0000_0000, 4'd2}   // R4 R6 go beats dec, ignored
  };

  function automatic logic [7:0] asc(input logic [3:0] n);
    return (n <= 4'd9) ? (8'd48 + 8'(n)) : (8'd65 + 8'(n) - 8'd10);
  endfunction

  function automatic logic [127:0] hash_line(input logic [63:0] h, input int s, input bit hide);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) begin
      r[8*i +: 8] = (hide && i == s) ? 8'd32 : asc(h[63-4*i -: 4]);
    end
    return r;
  endfunction

  function automatic logic [127:0] min_line(input logic [15:0] m);
    logic [127:0] r = {16{8'd32}};
    for (int k = 0; k < 4; k++) r[8*(15-k) +: 8] = asc(m[4*k +: 4]);
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [3:0] b, input logic s);
    @(negedge clk);
    btn = b; sw = s;
    @(negedge clk);
    btn = 4'h0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] h;
    logic [15:0] m;
    logic        prev;
    int          n;
    string       key_s;

    key_s = "CRACKED PLAIN 42";
    for (int i = 0; i < 16; i++) found_key[8*i +: 8] = key_s[i];

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 hash",   target_hash, 0);
    check("R1 sel",    blink_idx, 0);
    check("R1 run",    engine_run, 0);
    check("R1 min",    minutes, 0);
    check("R1 blink",  blink_on, 1);
    check("R5 line1",  line1, hash_line(64'h0, 0, 0));
    check("R5 line2",  line2, {16{8'd32}});

    for (int v = 0; v < NVEC; v++) begin
      pulse(VEC[v][72:69], VEC[v][68]);
      settle();
      check("R2/R3/R4 hash", target_hash, VEC[v][67:4]);
      check("R2/R3/R4 sel",  blink_idx, VEC[v][3:0]);
      check("R6 run low",    engine_run, 0);
    end
    h = 64'h1F10_0000_0000_0000;

    // R3 saturate at the right end
    for (int i = 0; i < 20; i++) pulse(4'b1000, 1'b1);
    settle();
    check("R3 sat right", blink_idx, 15);
    check("R3 hash kept", target_hash, h);

    // R5 blink period and blanking
    prev = blink_on;
    n = 0;
    while (blink_on == prev && n < 50) begin @(negedge clk); n++; end
    prev = blink_on;
    n = 0;
    while (blink_on == prev && n < 50) begin @(negedge clk); n++; end
    check("R5 blink period", n, BLINK);
    while (blink_on) @(negedge clk);
    check("R5 hidden digit", line1, hash_line(h, 15, 1));
    check("R5 line2 blank",  line2, {16{8'd32}});
    while (!blink_on) @(negedge clk);
    check("R5 shown digit",  line1, hash_line(h, 15, 0));

    // R6 start
    pulse(4'b0001, 1'b0);
    settle();
    check("R6 run high", engine_run, 1);
    check("R6 min zero", minutes, 0);

    // R7 edits ignored in running
    pulse(4'b0100, 1'b0);
    pulse(4'b0010, 1'b0);
    pulse(4'b1000, 1'b0);
    settle();
    check("R7 hash", target_hash, h);
    check("R7 sel",  blink_idx, 15);
    while (blink_on) @(negedge clk);
    check("R7 no blank", line1, hash_line(h, 15, 0));

    // R8 minute period
    n = 0;
    while (minutes != 16'd1 && n < 100) begin @(negedge clk); n++; end
    n = 0;
    while (minutes != 16'd2 && n < 100) begin @(negedge clk); n++; end
    check("R8 minute period", n, CYC);
    settle();
    check("R8 line2", line2, min_line(16'd2));

    // R10 go without switch ignored in running
    pulse(4'b0001, 1'b0);
    settle();
    check("R10 stay run", engine_run, 1);

    // R9 found
    @(negedge clk);
    found_i = 1'b1;
    @(negedge clk);
    found_i = 1'b0;
    m = minutes;
    settle();
    check("R9 run low", engine_run, 0);
    check("R9 key",     line1, found_key);
    repeat (3*CYC) @(negedge clk);
    check("R9 frozen",  minutes, m);
    check("R9 line2",   line2, min_line(m));

    pulse(4'b0001, 1'b0);
    settle();
    check("R10 stay found", line1, found_key);

    pulse(4'b0001, 1'b1);
    settle();
    check("R10 run low", engine_run, 0);
    check("R10 hash",    target_hash, h);
    check("R10 sel",     blink_idx, 15);
    check("R10 line2",   line2, {16{8'd32}});

    // R9 found ignored in setup
    @(negedge clk);
    found_i = 1'b1;
    @(negedge clk);
    found_i = 1'b0;
    settle();
    check("R9 ignore run", engine_run, 0);
    check("R9 ignore min", minutes, m);
    check("R9 ignore line2", line2, {16{8'd32}});

    // R6 restart clears, R10 cancel from running
    pulse(4'b0001, 1'b0);
    settle();
    check("R6 restart", engine_run, 1);
    check("R6 cleared", minutes, 0);
    pulse(4'b0001, 1'b1);
    settle();
    check("R10 cancel", engine_run, 0);
    check("R10 cancel hash", target_hash, h);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule